// File: doc/BRIEF.md
# Maskable DMA Interrupt Status Controller

This block gathers per-cause event strobes from a DMA channel into a sticky status vector. It combines that vector with a software-programmed enable mask to decide when to interrupt the host. Software reads the pending causes and acknowledges them by writing ones to a clear register. It also programs which causes may interrupt. A small control register selects how the interrupt is delivered: either a level line that stays high while any enabled cause is pending, or a one-cycle message request that carries the effective cause vector.

A cause is acknowledged with a write-one-to-clear access. This clear is race-safe: if an event arrives in the same cycle as the clear for its bit, the event wins and the bit stays pending. No completion is lost when hardware reports a new event while software is servicing an older one. Masking only gates delivery; status keeps recording every implemented cause.

Top module: `dma_irq_status`

## Requirements
- R1: After reset the status and enable registers are all zero, the delivery mode reads 1 (wired), `irq` is low and `msg_valid` is low.
- R2: An event bit in the implemented set {0,1,9,10,11,14} is recorded into status on the next clock, whatever the enable mask holds. Status reads at offset 0x100. Event bits outside that set are never recorded and read as zero.
- R3: A write to offset 0x108 clears exactly the status bits whose write-data bit is 1. Bits written as 0 are left unchanged.
- R4: When an event and a clear hit the same status bit in one cycle, the bit is pending after that clock.
- R5: The enable register at offset 0x110 is read and written as a whole. Only the implemented bit positions are stored, and writing zero masks every cause.
- R6: In wired mode (control bits [3:0] equal 1), `irq` is high exactly when status AND enable is nonzero. It stays high until every effective cause is cleared or masked.
- R7: In any other mode value, `irq` stays low. `msg_valid` pulses for one cycle whenever a bit of the effective cause becomes set that was clear in the previous cycle, and `msg_cause` carries the effective cause vector. A cause that remains pending does not pulse again.
- R8: The control register at offset 0x004 reads back its low 4 bits. Writes to the status offset have no effect, and reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| ev_in | input | 16 | Per-cause event strobes, one bit per cause |
| irq | output | 1 | Level interrupt line (wired mode) |
| msg_valid | output | 1 | One-cycle message interrupt request (message mode) |
| msg_cause | output | 16 | Effective cause vector (status AND enable) |

## Verification
Random cycles mix sparse and dense event vectors with clear, enable, mode and status writes. Each cycle is compared against a bench model of the status, the mask and the delivery output. The dense event vectors, which include unimplemented bit positions, show the difference between recorded and discarded causes. Directed cases then target the same-cycle event-and-clear collision, a partial clear that must leave its neighbours untouched, recording under a zero mask, and a held cause in message mode that must pulse once and then stay quiet. The same held cause in wired mode must keep the line high.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int CW = 16,
  parameter int AW = 12,
  parameter logic [CW-1:0] IMPL_MASK = 16'h4E03,
  parameter logic [AW-1:0] CTRL_OFS = 12'h004,
  parameter logic [AW-1:0] STAT_OFS = 12'h100,
  parameter logic [AW-1:0] CLR_OFS  = 12'h108,
  parameter logic [AW-1:0] EN_OFS   = 12'h110,
  parameter logic [3:0]    WIRED_MODE = 4'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic [CW-1:0] ev_in,
  output logic          irq,
  output logic          msg_valid,
  output logic [CW-1:0] msg_cause
);

  logic [CW-1:0] status_q, enable_q, eff_q;
  logic [3:0]    mode_q;
  logic [CW-1:0] eff, clr_vec, set_vec;
  logic          wired;

  assign clr_vec = (reg_we && reg_addr == CLR_OFS) ? reg_wdata : '0;
  assign set_vec = ev_in & IMPL_MASK;
  assign eff     = status_q & enable_q;
  assign wired   = (mode_q == WIRED_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      mode_q   <= WIRED_MODE;
      eff_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      eff_q    <= eff;
      if (reg_we && reg_addr == EN_OFS)   enable_q <= reg_wdata & IMPL_MASK;
      if (reg_we && reg_addr == CTRL_OFS) mode_q   <= reg_wdata[3:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_OFS)      reg_rdata = status_q;
    else if (reg_addr == EN_OFS)   reg_rdata = enable_q;
    else if (reg_addr == CTRL_OFS) reg_rdata[3:0] = mode_q;
  end

  assign irq       = wired && (eff != '0);
  assign msg_valid = !wired && ((eff & ~eff_q) != '0);
  assign msg_cause = eff;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == CLR_OFS) |=> ((status_q & $past(reg_wdata & ~ev_in)) == '0));

  assert_level_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_we) |=> irq);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> (!irq && !msg_valid));

  assert_one_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !irq);

endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  localparam logic [15:0] IMPL = 16'h4E03;
  localparam logic [11:0] A_CTRL = 12'h004, A_STAT = 12'h100, A_CLR = 12'h108, A_EN = 12'h110;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, ev_in = 0;
  logic [15:0] reg_rdata, msg_cause;
  logic irq, msg_valid;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_st = 0, m_en = 0, m_prev = 0;
  logic [3:0]  m_mode = 4'd1;

  always #5 clk = ~clk;

  dma_irq_status u_dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
                        .ev_in, .irq, .msg_valid, .msg_cause);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return (m_mode == 4'd1) && ((m_st & m_en) != 0);
  endfunction

  function automatic logic exp_msg();
    return (m_mode != 4'd1) && (((m_st & m_en) & ~m_prev) != 0);
  endfunction

  task automatic read_reg(input logic [11:0] a, output logic [15:0] d);
    reg_we = 0; reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [15:0] d, input logic [15:0] ev);
    reg_we = we; reg_addr = a; reg_wdata = d; ev_in = ev;
    m_prev = m_st & m_en;
    if (we && a == A_CLR)  m_st = m_st & ~d;
    if (we && a == A_EN)   m_en = d & IMPL;
    if (we && a == A_CTRL) m_mode = d[3:0];
    m_st = m_st | (ev & IMPL);
    @(posedge clk); @(negedge clk);
    reg_we = 0; ev_in = 0;
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    check({tag, " irq"}, {15'd0, irq}, {15'd0, exp_irq()});
    check({tag, " msg_valid"}, {15'd0, msg_valid}, {15'd0, exp_msg()});
    check({tag, " msg_cause"}, msg_cause, m_st & m_en);
    read_reg(A_STAT, d); check({tag, " status"}, d, m_st);
  endtask

  initial begin
    #100000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);

    read_reg(A_STAT, d); check("R1 status", d, 16'h0);
    read_reg(A_EN, d);   check("R1 enable", d, 16'h0);
    read_reg(A_CTRL, d); check("R1 mode", d, 16'h1);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 msg", {15'd0, msg_valid}, 16'h0);
    read_reg(12'h3F0, d); check("R8 unmapped", d, 16'h0);

    // R2: recorded while masked, unimplemented bits dropped
    step(1'b0, A_STAT, 16'h0, 16'hFFFF);
    check_all("R2 masked record");
    check("R2 no irq when masked", {15'd0, irq}, 16'h0);
    // R8: status write ignored
    step(1'b1, A_STAT, 16'h0000, 16'h0);
    check_all("R8 status ro");
    // R5: enable readback
    step(1'b1, A_EN, 16'hFFFF, 16'h0);
    read_reg(A_EN, d); check("R5 enable impl bits", d, IMPL);
    check_all("R6 wired on");
    // R3: partial clear
    step(1'b1, A_CLR, 16'h0601, 16'h0);
    check_all("R3 partial clear");
    // R4: same-cycle event and clear
    step(1'b1, A_CLR, 16'h0002, 16'h0002);
    check_all("R4 set wins");
    check("R4 bit1 pending", m_st & 16'h2, 16'h2);
    // R6: held level across idle cycles
    step(1'b0, A_STAT, 16'h0, 16'h0);
    check_all("R6 held");
    step(1'b1, A_CLR, 16'hFFFF, 16'h0);
    check_all("R6 cleared");
    // R7: message mode single pulse
    step(1'b1, A_CTRL, 16'h0002, 16'h0);
    read_reg(A_CTRL, d); check("R8 mode read", d, 16'h2);
    step(1'b0, A_STAT, 16'h0, 16'h4000);
    check_all("R7 pulse");
    check("R7 pulse seen", {15'd0, msg_valid}, 16'h1);
    step(1'b0, A_STAT, 16'h0, 16'h0);
    check_all("R7 no repeat");
    check("R7 quiet", {15'd0, msg_valid}, 16'h0);
    // R5: zero enable masks
    step(1'b1, A_EN, 16'h0000, 16'h0001);
    check_all("R5 mask all");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [15:0] ev;
      logic [15:0] w;
      op = 3'($urandom % 8);
      ev = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
      w  = 16'($urandom);
      case (op)
        3'd0, 3'd1: step(1'b1, A_CLR, w, ev);
        3'd2: step(1'b1, A_EN, w, ev);
        3'd3: step(1'b1, A_CTRL, {12'd0, ($urandom % 2 == 0) ? 4'd1 : 4'($urandom)}, ev);
        3'd4: step(1'b1, A_STAT, w, ev);
        default: step(1'b0, A_STAT, 16'h0, ev);
      endcase
      check_all("R2 R3 R4 R6 R7 random");
      read_reg(A_EN, d); check("R5 random enable", d, m_en);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule